// File: doc/BRIEF.md
# Sequential Unsigned Divider, 32 by 16

This block divides a 32-bit unsigned dividend by a 16-bit unsigned divisor and returns a 16-bit quotient and a 16-bit remainder. A caller presents both operands with a one-cycle `start` pulse. The block checks the operands once. If they are valid, it runs a fixed sequence of restoring shift-and-subtract steps, one per clock. One working register holds the partial remainder in its upper half and gathers quotient bits in its lower half.

Two faults are caught in the cycle that accepts the start, before any step runs. The first is a divisor of zero. The second is a quotient that would not fit in 16 bits, which happens when the upper half of the dividend is not below the divisor. `busy` is high while the steps run. `done` pulses for one cycle when a result or a fault verdict is ready. The fault flags and the result outputs hold their values until the next accepted start.

Top module: `sdiv_top`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `div_zero` and `overflow` are all 0.
- R2: A start with divisor 0 is answered in the cycle after the start edge with `done`=1 and `div_zero`=1, and `busy` never rises.
- R3: A start with a nonzero divisor and dividend[31:16] >= divisor is answered in the cycle after the start edge with `done`=1, `overflow`=1 and `div_zero`=0, and `busy` never rises. This includes the case where the upper half equals the divisor.
- R4: A valid start raises `busy` for exactly 16 cycles after the start edge. `done` is high in the 17th cycle, while `busy` is low.
- R5: After a valid division, `quotient` equals dividend / divisor and `remainder` equals dividend % divisor.
- R6: Whenever `done` is high with no fault flag set, `remainder` is less than the latched divisor.
- R7: A `start` pulse while `busy` is high is ignored. The running division finishes at the same cycle and with the same result as if that pulse had not arrived.
- R8: `quotient`, `remainder`, `div_zero` and `overflow` keep their values from the `done` cycle until the next accepted start.
- R9: `done` is never high on two consecutive cycles.
- R10: A zero divisor takes priority over overflow: `overflow` stays 0 when the divisor is 0.
- R11: When a step shifts a 1 out of the top of the working register, the subtraction is forced. For example, 0xFFFEFFFF / 0xFFFF gives quotient 0xFFFF and remainder 0xFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Operand strobe, accepted only when idle |
| dividend | input | 32 | Unsigned dividend, sampled on an accepted start |
| divisor | input | 16 | Unsigned divisor, sampled on an accepted start |
| busy | output | 1 | High while the iteration steps run |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 16 | Quotient, valid from `done` when no flag is set |
| remainder | output | 16 | Remainder, valid from `done` when no flag is set |
| div_zero | output | 1 | Divisor was zero |
| overflow | output | 1 | Quotient would need more than 16 bits |

## Verification
The bench builds the block with its default divisor width of 16, so the dividend is 32 bits and there are 16 steps. At that size the extreme divisors 1 and 0xFFFF can be reached directly, as can the boundary where the dividend's upper half equals the divisor. Dividends with a set top bit exercise the forced subtraction path, where a carry comes out of the working register. The behavioural model in the bench predicts `busy` and `done` on every cycle, and it predicts the results with plain integer division and modulo.

// File: rtl/sdiv_pkg.sv
// Package: shared types for the sequential divider.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package sdiv_pkg;
    // Verdict of the operand check made on an accepted start.
    typedef enum logic [1:0] {
        CHK_OK   = 2'd0,
        CHK_ZERO = 2'd1,
        CHK_OVF  = 2'd2
    } chk_e;
endpackage

// File: rtl/sdiv_precheck.sv
// Module: sdiv_precheck
// Classifies operands before any iteration. A zero divisor wins over
// overflow. Overflow means the dividend's upper half is >= the divisor,
// so the quotient would need more than DVS_W bits.
// Assumes: purely combinational, operands stable while sampled.
module sdiv_precheck
    import sdiv_pkg::*;
#(
    parameter int DVS_W = 16
) (
    input  logic [DVS_W-1:0] dvd_hi,
    input  logic [DVS_W-1:0] dvs,
    output chk_e             verdict
);
    // Priority classification of the operand pair.
    always_comb begin
        if (dvs == '0)
            verdict = CHK_ZERO;
        else if (dvd_hi >= dvs)
            verdict = CHK_OVF;
        else
            verdict = CHK_OK;
    end
endmodule

// File: rtl/sdiv_step.sv
// Module: sdiv_step
// One restoring step: shift the working register left, with a 0 entering
// the LSB. If a 1 leaves the top, or the upper half is >= the divisor,
// subtract the divisor from the upper half and set the LSB.
// Assumes: dvs is nonzero and the upper half of work is below dvs.
module sdiv_step #(
    parameter int DVS_W = 16
) (
    input  logic [2*DVS_W-1:0] work,
    input  logic [DVS_W-1:0]   dvs,
    output logic [2*DVS_W-1:0] work_nxt
);
    localparam int DVD_W = 2 * DVS_W;

    logic               carry_out;
    logic [DVD_W-1:0]   shifted;
    logic [DVS_W:0]     diff;
    logic               fits;

    // Shift and trial-subtract; the borrow of the wide difference decides.
    always_comb begin
        carry_out = work[DVD_W-1];
        shifted   = {work[DVD_W-2:0], 1'b0};
        diff      = {1'b0, shifted[DVD_W-1:DVS_W]} - {1'b0, dvs};
        fits      = carry_out | ~diff[DVS_W];
        if (fits)
            work_nxt = {diff[DVS_W-1:0], shifted[DVS_W-1:1], 1'b1};
        else
            work_nxt = shifted;
    end
endmodule

// File: rtl/sdiv_ctrl.sv
// Module: sdiv_ctrl
// Sequencer. Accepts start only when idle. Faults finish at once;
// valid operands run DVS_W steps. Generates busy, the done pulse and
// sticky fault flags that clear on the next accepted start.
// Assumes: synchronous active-low reset.
module sdiv_ctrl
    import sdiv_pkg::*;
#(
    parameter int DVS_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  chk_e verdict,
    output logic load,
    output logic step_en,
    output logic busy,
    output logic done,
    output logic err_zero,
    output logic err_ovf
);
    localparam int CNT_W = (DVS_W > 1) ? $clog2(DVS_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DVS_W - 1);

    logic             accept;
    logic [CNT_W-1:0] cnt;

    // Decode an accepted start and the step enable.
    always_comb begin
        accept  = start & ~busy;
        load    = accept & (verdict == CHK_OK);
        step_en = busy;
    end

    // Sequence state, step counter, done pulse and fault flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            err_zero <= 1'b0;
            err_ovf  <= 1'b0;
            cnt      <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                err_zero <= (verdict == CHK_ZERO);
                err_ovf  <= (verdict == CHK_OVF);
                cnt      <= '0;
                if (verdict == CHK_OK)
                    busy <= 1'b1;
                else
                    done <= 1'b1;
            end else if (busy) begin
                cnt <= cnt + 1'b1;
                if (cnt == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    assert_zero_prio_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_zero && err_ovf));
    assert_fault_fast_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && verdict != CHK_OK) |=> (done && !busy));
endmodule

// File: rtl/sdiv_top.sv
// Module: sdiv_top
// Sequential unsigned divider: (2*DVS_W)-bit dividend by DVS_W-bit divisor.
// Holds the working register and the latched divisor, and wires the
// check, step and sequencer units together.
// Assumes: operands are valid in the cycle start is high.
module sdiv_top
    import sdiv_pkg::*;
#(
    parameter int DVS_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [2*DVS_W-1:0]   dividend,
    input  logic [DVS_W-1:0]     divisor,
    output logic                 busy,
    output logic                 done,
    output logic [DVS_W-1:0]     quotient,
    output logic [DVS_W-1:0]     remainder,
    output logic                 div_zero,
    output logic                 overflow
);
    localparam int DVD_W = 2 * DVS_W;

    chk_e             verdict;
    logic             load;
    logic             step_en;
    logic [DVD_W-1:0] work_q;
    logic [DVD_W-1:0] work_nxt;
    logic [DVS_W-1:0] dvs_q;

    sdiv_precheck #(.DVS_W(DVS_W)) u_check (
        .dvd_hi  (dividend[DVD_W-1:DVS_W]),
        .dvs     (divisor),
        .verdict (verdict)
    );

    sdiv_step #(.DVS_W(DVS_W)) u_step (
        .work     (work_q),
        .dvs      (dvs_q),
        .work_nxt (work_nxt)
    );

    sdiv_ctrl #(.DVS_W(DVS_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .verdict  (verdict),
        .load     (load),
        .step_en  (step_en),
        .busy     (busy),
        .done     (done),
        .err_zero (div_zero),
        .err_ovf  (overflow)
    );

    // Load operands on an accepted start, then advance one step per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q <= '0;
            dvs_q  <= '0;
        end else if (load) begin
            work_q <= dividend;
            dvs_q  <= divisor;
        end else if (step_en) begin
            work_q <= work_nxt;
        end
    end

    // Result fields of the working register.
    always_comb begin
        quotient  = work_q[DVS_W-1:0];
        remainder = work_q[DVD_W-1:DVS_W];
    end

    assert_rem_below_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero && !overflow) |-> (remainder < dvs_q));
    assert_busy_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(dvs_q));
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start && !done) |=> ($stable(work_q) && $stable(div_zero) && $stable(overflow)));
endmodule

// File: tb/sdiv_top_bench.sv
module sdiv_top_bench;
    localparam int DVS_W = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] dividend = '0;
    logic [15:0] divisor = '0;
    logic        busy, done, div_zero, overflow;
    logic [15:0] quotient, remainder;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sdiv_top #(.DVS_W(DVS_W)) u_sdiv_top (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done),
        .quotient(quotient), .remainder(remainder),
        .div_zero(div_zero), .overflow(overflow)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Run one division; the model predicts busy/done on every cycle.
    // inject: pulse start with other operands mid-run (R7).
    task automatic run_div(input logic [31:0] a, input logic [15:0] b, input bit inject, input string tag);
        bit zero_case, ovf_case;
        int last;
        int mism;
        longint exp_q, exp_r;
        zero_case = (b == 0);
        ovf_case  = !zero_case && (a[31:16] >= b);
        last = (zero_case || ovf_case) ? 1 : 17;
        mism = 0;
        @(negedge clk);
        dividend = a; divisor = b; start = 1'b1;
        for (int i = 1; i <= last; i++) begin
            @(negedge clk);
            start = 1'b0;
            if (inject && i == 5) begin
                start = 1'b1; dividend = 32'h0000_0001; divisor = 16'h0003;
            end
            if (busy !== ((last == 17) && (i <= 16))) mism++;
            if (done !== (i == last)) mism++;
        end
        start = 1'b0;
        check(mism == 0, {"R4 busy/done trace ", tag}, mism, 0);
        check(done && !busy, {"R9 done at end ", tag}, {done, busy}, 2'b10);
        if (zero_case) begin
            check(div_zero === 1'b1, {"R2 div_zero ", tag}, div_zero, 1);
            check(overflow === 1'b0, {"R10 overflow low on zero ", tag}, overflow, 0);
        end else if (ovf_case) begin
            check(overflow === 1'b1 && div_zero === 1'b0, {"R3 overflow ", tag}, {overflow, div_zero}, 2'b10);
        end else begin
            exp_q = longint'(a) / longint'(b);
            exp_r = longint'(a) % longint'(b);
            check(div_zero === 1'b0 && overflow === 1'b0, {"R5 no flags ", tag}, {div_zero, overflow}, 0);
            check(quotient == exp_q[15:0], {"R5 quotient ", tag}, quotient, exp_q);
            check(remainder == exp_r[15:0], {"R5 remainder ", tag}, remainder, exp_r);
            check(remainder < b, {"R6 remainder below divisor ", tag}, remainder, b);
        end
        // R9: done must fall next cycle; R8: outputs hold while idle.
        begin
            logic [15:0] q0, r0;
            logic z0, o0;
            q0 = quotient; r0 = remainder; z0 = div_zero; o0 = overflow;
            @(negedge clk);
            check(done === 1'b0, {"R9 single pulse ", tag}, done, 0);
            dividend = ~a; divisor = ~b;
            repeat (2) @(negedge clk);
            check(quotient == q0 && remainder == r0 && div_zero == z0 && overflow == o0,
                  {"R8 hold ", tag}, {quotient, remainder, div_zero, overflow}, {q0, r0, z0, o0});
        end
    endtask

    initial begin
        logic [15:0] rb, rhi;
        logic [31:0] ra;
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && div_zero === 1'b0 && overflow === 1'b0,
              "R1 reset state", {busy, done, div_zero, overflow}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_div(32'h0000_1234, 16'h0000, 0, "b=0");
        run_div(32'hFFFF_FFFF, 16'h0000, 0, "b=0 big a");
        run_div(32'h0005_0000, 16'h0005, 0, "hi==b");
        run_div(32'hFFFF_0000, 16'h1234, 0, "hi>b");
        run_div(32'h0000_ABCD, 16'h0001, 0, "b=1");
        run_div(32'h0000_0000, 16'h0007, 0, "a=0");
        run_div(32'hFFFE_FFFF, 16'hFFFF, 0, "R11 carry b=FFFF");
        run_div(32'h8000_0000, 16'hFFFF, 0, "R11 carry top bit");
        run_div(32'h0004_FFFF, 16'h0005, 0, "hi=b-1");
        run_div(32'h1234_5678, 16'h9ABC, 1, "R7 start while busy");
        for (int k = 0; k < 40; k++) begin
            rb  = 16'($urandom);
            if (rb == 0) rb = 16'h00A5;
            rhi = 16'($urandom % rb);
            ra  = {rhi, 16'($urandom)};
            run_div(ra, rb, (k % 7) == 3, "random");
        end
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule